// File: doc/BRIEF.md
# Selectable-Source Baud Tick Generator

This block produces the timing enables for a serial port: a one-cycle pulse per bit period and a second pulse stream at sixteen times the bit rate for the receiver's oversampler. It runs in the functional clock domain. The time base is either every functional clock cycle or a reference enable pulse that a crystal-derived path delivers already synchronised into this domain.

A single 32-bit configuration word, loaded by a write strobe, selects the source and a fixed prescale: divide by 4 on the functional clock, and divide by 3 or by 2 on the reference path. It also holds the divisor N, which stretches the bit period to N+1 prescaled ticks, and a use flag that gates the whole generator. Software programs N as the rounded ratio of prescaled rate to bit rate, minus one, for bit rates from 50 to 4,000,000. Each write restarts every counter so the first bit period after it is exact.

Top module: `baud_tick_gen`

## Requirements
- R1: During and after reset both outputs are low, and they stay low until a configuration write with the use flag set.
- R2: While the use flag (bit 23 of the configuration word) is clear, neither output pulses, whatever the divisor, the source selection or the reference pulses.
- R3: With bit 24 clear the source is every functional clock cycle and the prescale is 4; bit 27 has no effect in this case.
- R4: With bit 24 set the source is `xtal_tick_i` and the prescale is 3, or 2 when bit 27 is also set; cycles without a reference pulse do not advance the generator.
- R5: With divisor N in bits 22:0, a bit period spans N+1 prescaled ticks; `bit_tick_o` is high for the one cycle after the clock edge that consumes the last source event of the period.
- R6: A configuration write restarts the prescaler, the divisor counter and the oversampling phase; a source event in the write cycle is discarded, and the first bit tick follows exactly P*(N+1) later source events.
- R7: With N+1 of 16 or more, `os_tick_o` pulses exactly 16 times per bit period, on prescaled tick k (counting 1 to N+1 within the period) whenever floor(16k/(N+1)) exceeds floor(16(k-1)/(N+1)); the last of them coincides with the bit tick.
- R8: With N+1 below 16, `os_tick_o` pulses on every prescaled tick.
- R9: Each output pulse lasts one cycle; an output is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xtal_tick_i | input | 1 | Reference-path event, one cycle per reference tick, already in this clock domain |
| cfg_wr_i | input | 1 | Loads `cfg_i` and restarts all counters |
| cfg_i | input | 32 | Configuration word: divisor 22:0, use 23, reference select 24, reference halving 27 |
| bit_tick_o | output | 1 | Bit-rate enable pulse |
| os_tick_o | output | 1 | Sixteen-times oversampling enable pulse |

## Verification
The divisor is swept through every value from 0 to 33 on the functional path, and from 0 to 20 on both reference prescales. This covers periods below, at and above sixteen prescaled ticks, so the every-tick oversampling mode is told apart from the distributed one, and the exact-sixteen boundary is told apart from both. On the reference path the bench drives the reference pulse from a pseudo-random sequence, which separates the counting of source events from the counting of clock cycles. Separate runs clear the use flag, set bit 27 with the functional clock selected, and rewrite the word in the middle of a period, to show gating, an ignored field and a clean restart. Each cycle the expected pulses are computed from the number of source events consumed since the last write.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  localparam int unsigned CFG_W    = 32;
  localparam int unsigned DIV_W    = 23;
  localparam int unsigned USE_BIT  = 23;
  localparam int unsigned XTAL_BIT = 24;
  localparam int unsigned HALF_BIT = 27;

  typedef struct packed {
    logic             use_en;
    logic             xtal_sel;
    logic             xtal_half;
    logic [DIV_W-1:0] div;
  } cfg_t;

  function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    cfg_t c;
    c.use_en    = w[USE_BIT];
    c.xtal_sel  = w[XTAL_BIT];
    c.xtal_half = w[HALF_BIT];
    c.div       = w[DIV_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned FAST_DIV = 4,
  parameter int unsigned XTAL_DIV = 3,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic xtal_sel_i,
  input  logic xtal_half_i,
  input  logic xtal_tick_i,
  output logic pre_tick_o
);
  localparam int unsigned MAX_DIV = (FAST_DIV > XTAL_DIV) ?
      ((FAST_DIV > HALF_DIV) ? FAST_DIV : HALF_DIV) :
      ((XTAL_DIV > HALF_DIV) ? XTAL_DIV : HALF_DIV);
  localparam int unsigned PW = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam logic [PW-1:0] LIM_FAST = PW'(FAST_DIV - 1);
  localparam logic [PW-1:0] LIM_XTAL = PW'(XTAL_DIV - 1);
  localparam logic [PW-1:0] LIM_HALF = PW'(HALF_DIV - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] limit;
  logic          src_en;

  always_comb begin
    if (xtal_sel_i) begin
      limit  = xtal_half_i ? LIM_HALF : LIM_XTAL;
      src_en = xtal_tick_i;
    end else begin
      limit  = LIM_FAST;
      src_en = 1'b1;
    end
  end

  assign pre_tick_o = run_i && !clr_i && src_en && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !run_i)   cnt_q <= '0;
    else if (src_en)            cnt_q <= pre_tick_o ? '0 : cnt_q + 1'b1;
  end

  // R3 / R4: phase never passes the selected prescale
  p_pre_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int unsigned DW = 23
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          pre_tick_i,
  input  logic [DW-1:0] div_i,
  output logic          wrap_o
);
  logic [DW-1:0] cnt_q;

  assign wrap_o = pre_tick_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || !run_i) cnt_q <= '0;
    else if (pre_tick_i)      cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  // R5: count stays within the programmed period
  p_div_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= div_i);
endmodule

// File: rtl/baud_os_gen.sv
module baud_os_gen #(
  parameter int unsigned DW      = 23,
  parameter int unsigned OS_LOG2 = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          pre_tick_i,
  input  logic [DW-1:0] div_i,
  output logic          os_o
);
  localparam int unsigned AW = DW + 2;
  localparam logic [AW-1:0] OS_N = AW'(1 << OS_LOG2);

  logic [AW-1:0] acc_q;
  logic [AW-1:0] period;
  logic [AW-1:0] sum;
  logic          short_per;
  logic          hit;

  assign period    = {2'b00, div_i} + 1'b1;
  assign short_per = period < OS_N;
  assign sum       = acc_q + OS_N;
  assign hit       = sum >= period;
  assign os_o      = pre_tick_i && (short_per || hit);

  // Bresenham accumulator: 16 hits per period, spread evenly
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       acc_q <= '0;
    else if (clr_i || !run_i)          acc_q <= '0;
    else if (pre_tick_i && !short_per) acc_q <= hit ? sum - period : sum;
  end

  // R7: residue always below the period
  p_acc_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !short_per |-> acc_q < period);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned FAST_DIV = 4,
  parameter int unsigned XTAL_DIV = 3,
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned OS_LOG2  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xtal_tick_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             bit_tick_o,
  output logic             os_tick_o
);
  cfg_t cfg_q;
  logic pre_tick;
  logic wrap;
  logic os_hit;
  logic bit_q;
  logic os_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_wr_i) cfg_q <= decode_cfg(cfg_i);
  end

  baud_prescaler #(
    .FAST_DIV(FAST_DIV), .XTAL_DIV(XTAL_DIV), .HALF_DIV(HALF_DIV)
  ) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cfg_wr_i),
    .run_i      (cfg_q.use_en),
    .xtal_sel_i (cfg_q.xtal_sel),
    .xtal_half_i(cfg_q.xtal_half),
    .xtal_tick_i(xtal_tick_i),
    .pre_tick_o (pre_tick)
  );

  baud_divider #(.DW(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cfg_wr_i),
    .run_i     (cfg_q.use_en),
    .pre_tick_i(pre_tick),
    .div_i     (cfg_q.div),
    .wrap_o    (wrap)
  );

  baud_os_gen #(.DW(DIV_W), .OS_LOG2(OS_LOG2)) u_os (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cfg_wr_i),
    .run_i     (cfg_q.use_en),
    .pre_tick_i(pre_tick),
    .div_i     (cfg_q.div),
    .os_o      (os_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b0;
      os_q  <= 1'b0;
    end else begin
      bit_q <= wrap;
      os_q  <= os_hit;
    end
  end

  assign bit_tick_o = bit_q;
  assign os_tick_o  = os_q;

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.use_en |=> !bit_tick_o && !os_tick_o);
  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> !bit_tick_o && !os_tick_o);
  p_bit_os_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> os_tick_o);
  p_bit_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |=> !bit_tick_o);
  p_os_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    os_tick_o |=> !os_tick_o);
endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        xtal_tick;
  logic        cfg_wr;
  logic [31:0] cfg;
  logic        bit_tick;
  logic        os_tick;

  always #4 clk = ~clk;

  baud_tick_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .xtal_tick_i(xtal_tick),
    .cfg_wr_i(cfg_wr), .cfg_i(cfg),
    .bit_tick_o(bit_tick), .os_tick_o(os_tick)
  );

  int checks   = 0;
  int failures = 0;

  // bench model state
  logic [31:0] cur_cfg  = '0;
  longint      ev_cnt   = 0;
  logic        last_ev  = 1'b0;
  logic        prev_bit = 1'b0;
  logic        prev_os  = 1'b0;
  logic [15:0] lfsr     = 16'hACE1;
  int          bit_seen;

  function automatic longint pre_of(input logic [31:0] w);
    if (!w[24]) return 4;
    return w[27] ? 2 : 3;
  endfunction

  task automatic step(input string tag, input logic [31:0] wr_word, input logic do_wr);
    longint p, m, q, k;
    logic   eb, eo;
    @(negedge clk);
    p  = pre_of(cur_cfg);
    m  = longint'(cur_cfg[22:0]) + 1;
    eb = 1'b0;
    eo = 1'b0;
    if (cur_cfg[23] && last_ev && (ev_cnt % p == 0)) begin
      q  = ev_cnt / p;
      k  = ((q - 1) % m) + 1;
      eb = (k == m);
      eo = (m < 16) ? 1'b1 : ((16 * k) / m != (16 * (k - 1)) / m);
    end
    checks++;
    if (bit_tick !== eb) begin
      failures++;
      $display("FAIL %s bit_tick got=%0b exp=%0b ev=%0d", tag, bit_tick, eb, ev_cnt);
    end
    checks++;
    if (os_tick !== eo) begin
      failures++;
      $display("FAIL %s os_tick got=%0b exp=%0b ev=%0d", tag, os_tick, eo, ev_cnt);
    end
    checks++;
    if ((prev_bit && bit_tick === 1'b1) || (prev_os && os_tick === 1'b1)) begin
      failures++;
      $display("FAIL R9 back-to-back pulse got bit=%0b os=%0b exp=0", bit_tick, os_tick);
    end
    if (bit_tick === 1'b1) bit_seen++;
    prev_bit = (bit_tick === 1'b1);
    prev_os  = (os_tick === 1'b1);
    // drive the next cycle
    lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    xtal_tick = lfsr[0];
    cfg_wr    = do_wr;
    cfg       = wr_word;
    if (do_wr) begin
      cur_cfg = wr_word;
      ev_cnt  = 0;
      last_ev = 1'b0;
    end else if (cur_cfg[23] && (cur_cfg[24] ? xtal_tick : 1'b1)) begin
      ev_cnt++;
      last_ev = 1'b1;
    end else begin
      last_ev = 1'b0;
    end
  endtask

  task automatic run(input string tag, input logic [31:0] word, input int cycles, input int min_bits);
    bit_seen = 0;
    step(tag, word, 1'b1);
    for (int i = 0; i < cycles; i++) step(tag, '0, 1'b0);
    checks++;
    if (bit_seen < min_bits) begin
      failures++;
      $display("FAIL %s bit ticks seen got=%0d exp>=%0d", tag, bit_seen, min_bits);
    end
  endtask

  function automatic logic [31:0] mk(input logic use_b, input logic xs, input logic hf, input int n);
    logic [31:0] w = '0;
    w[22:0] = 23'(n);
    w[23]   = use_b;
    w[24]   = xs;
    w[27]   = hf;
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; xtal_tick = 1'b0; cfg_wr = 1'b0; cfg = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (bit_tick !== 1'b0 || os_tick !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset got=%0b%0b exp=00", bit_tick, os_tick);
    end
    rst_n = 1'b1;
    // R1: idle after reset with no write
    for (int i = 0; i < 30; i++) step("R1", '0, 1'b0);
    // R3 / R5 / R7 / R8: functional path divisor sweep
    for (int n = 0; n < 34; n++) run("R5", mk(1, 0, 0, n), 4 * (n + 1) * 3 + 2, 3);
    // R3: bit 27 ignored on the functional path
    run("R3", mk(1, 0, 1, 20), 4 * 21 * 3 + 2, 3);
    run("R7", mk(1, 0, 0, 15), 4 * 16 * 3 + 2, 3);
    run("R8", mk(1, 0, 0, 6), 4 * 7 * 3 + 2, 3);
    // R4: reference path, both prescales, pseudo-random reference pulses
    for (int n = 0; n < 21; n++) run("R4", mk(1, 1, 0, n), 3 * (n + 1) * 9 + 20, 2);
    for (int n = 0; n < 21; n++) run("R4", mk(1, 1, 1, n), 2 * (n + 1) * 9 + 20, 2);
    // R2: use flag clear on both paths
    run("R2", mk(0, 0, 0, 3), 120, 0);
    run("R2", mk(0, 1, 1, 0), 120, 0);
    // R6: rewrite mid-period, then restart timing
    run("R6", mk(1, 0, 0, 9), 25, 0);
    run("R6", mk(1, 0, 0, 12), 4 * 13 * 3 + 2, 3);
    run("R6", mk(1, 1, 0, 40), 50, 0);
    run("R6", mk(1, 0, 0, 39), 4 * 40 * 2 + 2, 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule